// File: doc/BRIEF.md
# Packet-Mode Radio Frame Builder and Parser

This block handles byte-level framing for a low-rate packet radio. On the transmit side the host first fills a payload buffer. It then pulses a start request together with a payload length. The block emits the frame one byte at a time toward the modulator, which sets the pace with a ready signal. The frame has four zero lead-in bytes, a delimiter byte 0xA7, a length byte, the payload read from the buffer, and a 16-bit check sequence that is computed while the payload streams out. When the last byte has been accepted, a single interrupt pulse reports completion.

On the receive side the block watches a qualified byte stream from the demodulator. It recognises a run of zero bytes followed by the delimiter. It then captures the length byte and refuses lengths that cannot be legal. The payload and check bytes are written into a receive buffer that the host reads through an asynchronous read port. When the frame is complete, one interrupt pulse is raised and a check-valid flag is published. This flag is suitable for driving onto a general-purpose pin. The payload length of the frame is published with it.

Top module: `phy_frame_engine`

## Requirements
- R1: After reset, txo_valid, tx_irq, rx_irq and crc_valid are 0 and rx_len is 0.
- R2: A transmitted frame is, in order: 4 bytes of 0x00, the delimiter 0xA7, one length byte equal to tx_len+2, the tx_len payload bytes from transmit buffer addresses 0 upward, then the check low byte and then the check high byte.
- R3: The check is CRC-16 with generator x^16+x^12+x^5+1 and initial value 0. It is processed least significant bit first, which is the reflected constant 0x8408. It covers the payload bytes only. For the nine ASCII bytes "123456789" it is 0x2189.
- R4: While txo_valid is 1 and txo_ready is 0, txo_data holds its value and txo_valid stays 1.
- R5: tx_irq is a single-cycle pulse. It is raised in the cycle after the check high byte is accepted, once per frame, and txo_valid is 0 while it is high.
- R6: A tx_start with tx_len above 125 is ignored. A tx_start while a frame is in progress is also ignored.
- R7: The receiver accepts the delimiter only when at least 2 consecutive 0x00 bytes immediately precede it. Otherwise no frame is started.
- R8: After a received frame, receive buffer addresses 0 to L-1 hold the L bytes that follow the length byte L (payload, then check low, then check high). rx_len reports L-2, which is never above 125.
- R9: crc_valid becomes 1 when the check recomputed over the received payload equals the received check bytes, and 0 otherwise. crc_valid and rx_len change only together with rx_irq.
- R10: A length byte above 127 or below 2 drops the frame with no rx_irq and no change to crc_valid or rx_len. The receiver then hunts for a new delimiter.
- R11: rx_irq is a single-cycle pulse in the cycle after the final check byte is accepted, once per frame.
- R12: Receive bytes with rxi_valid low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txb_we | input | 1 | Transmit buffer write enable |
| txb_addr | input | 7 | Transmit buffer write address |
| txb_wdata | input | 8 | Transmit buffer write data |
| tx_start | input | 1 | Start request for one frame |
| tx_len | input | 7 | Payload length for the start request |
| txo_valid | output | 1 | Outgoing byte present |
| txo_data | output | 8 | Outgoing frame byte |
| txo_ready | input | 1 | Modulator takes the byte on this edge |
| tx_irq | output | 1 | Transmit-complete pulse |
| rxi_valid | input | 1 | Incoming byte qualifier |
| rxi_data | input | 8 | Incoming frame byte |
| rxb_addr | input | 7 | Receive buffer read address |
| rxb_rdata | output | 8 | Receive buffer read data (combinational) |
| rx_irq | output | 1 | Receive-complete pulse |
| crc_valid | output | 1 | Check result of the last received frame |
| rx_len | output | 7 | Payload length of the last received frame |

## Verification
The bound checker watches the following on every cycle:
- the interrupt pulses are one cycle wide;
- a stalled output byte stays stable;
- every transmitted frame starts with a zero byte;
- the end of transmission coincides with tx_irq;
- a start with an oversized length launches nothing;
- the receive flags move only with rx_irq, and rx_len stays within range.

Several behaviours can only be shown by the bench's scenarios. These are the exact byte order and check values of a frame, delimiter qualification by the preceding zero run, dropping of illegal length bytes and recovery afterwards, and the buffer contents after reception. The bench covers them with random and boundary payloads, gapped input and deliberate corruption.

// File: rtl/phy_frame_pkg.sv
package phy_frame_pkg;

    localparam logic [7:0]  LEAD_BYTE     = 8'h00;
    localparam logic [15:0] CRC_POLY_REFL = 16'h8408;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_LEAD,
        TX_DELIM,
        TX_LENGTH,
        TX_BODY,
        TX_CHK_LO,
        TX_CHK_HI
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_HUNT,
        RX_LENGTH,
        RX_BODY
    } rx_state_e;

    // One byte through the reflected CRC-16 register, low bit first.
    function automatic logic [15:0] crc16_step(input logic [15:0] crc_in,
                                               input logic [7:0]  data);
        logic [15:0] r;
        r = crc_in ^ {8'h00, data};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/pf_byte_ram.sv
module pf_byte_ram #(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/pf_tx_framer.sv
module pf_tx_framer
    import phy_frame_pkg::*;
#(
    parameter int          PAYLOAD_MAX = 125,
    parameter int          LEAD_LEN    = 4,
    parameter logic [7:0]  DELIM       = 8'hA7,
    parameter int          AW          = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] len,
    output logic [AW-1:0] rd_addr,
    input  logic [7:0]    rd_data,
    output logic          out_valid,
    output logic [7:0]    out_data,
    input  logic          out_ready,
    output logic          done_irq
);
    localparam logic [AW-1:0] MAX_LEN  = AW'(PAYLOAD_MAX);
    localparam logic [AW-1:0] LEAD_END = AW'(LEAD_LEN - 1);

    typedef struct packed {
        tx_state_e     state;
        logic [AW-1:0] cnt;
        logic [AW-1:0] len;
        logic [15:0]   crc;
        logic          irq;
    } tx_regs_t;

    localparam tx_regs_t TX_RESET = '{state: TX_IDLE, cnt: '0, len: '0, crc: '0, irq: 1'b0};

    tx_regs_t q, d;
    logic     take;

    always_comb begin
        d        = q;
        d.irq    = 1'b0;
        take     = out_valid && out_ready;
        unique case (q.state)
            TX_IDLE: begin
                if (start && (len <= MAX_LEN)) begin
                    d.state = TX_LEAD;
                    d.cnt   = '0;
                    d.len   = len;
                    d.crc   = '0;
                end
            end
            TX_LEAD: begin
                if (take) begin
                    if (q.cnt == LEAD_END) begin
                        d.state = TX_DELIM;
                        d.cnt   = '0;
                    end else begin
                        d.cnt = q.cnt + AW'(1);
                    end
                end
            end
            TX_DELIM: begin
                if (take) d.state = TX_LENGTH;
            end
            TX_LENGTH: begin
                if (take) begin
                    d.cnt   = '0;
                    d.state = (q.len == '0) ? TX_CHK_LO : TX_BODY;
                end
            end
            TX_BODY: begin
                if (take) begin
                    d.crc = crc16_step(q.crc, rd_data);
                    if (q.cnt == q.len - AW'(1)) begin
                        d.state = TX_CHK_LO;
                    end else begin
                        d.cnt = q.cnt + AW'(1);
                    end
                end
            end
            TX_CHK_LO: begin
                if (take) d.state = TX_CHK_HI;
            end
            TX_CHK_HI: begin
                if (take) begin
                    d.state = TX_IDLE;
                    d.irq   = 1'b1;
                end
            end
            default: d = TX_RESET;
        endcase
    end

    always_comb begin
        unique case (q.state)
            TX_LEAD:   out_data = LEAD_BYTE;
            TX_DELIM:  out_data = DELIM;
            TX_LENGTH: out_data = 8'(q.len) + 8'd2;
            TX_BODY:   out_data = rd_data;
            TX_CHK_LO: out_data = q.crc[7:0];
            TX_CHK_HI: out_data = q.crc[15:8];
            default:   out_data = 8'h00;
        endcase
    end

    assign out_valid = (q.state != TX_IDLE);
    assign rd_addr   = q.cnt;
    assign done_irq  = q.irq;

    always_ff @(posedge clk) begin
        if (!rst_n) q <= TX_RESET;
        else        q <= d;
    end

endmodule

// File: rtl/pf_rx_parser.sv
module pf_rx_parser
    import phy_frame_pkg::*;
#(
    parameter int         PAYLOAD_MAX = 125,
    parameter int         LEAD_MATCH  = 2,
    parameter logic [7:0] DELIM       = 8'hA7,
    parameter int         AW          = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic          done_irq,
    output logic          crc_ok,
    output logic [AW-1:0] pay_len
);
    localparam int            ZW        = $clog2(LEAD_MATCH + 1);
    localparam logic [ZW-1:0] Z_FULL    = ZW'(LEAD_MATCH);
    localparam logic [7:0]    TOTAL_MAX = 8'(PAYLOAD_MAX + 2);

    typedef struct packed {
        rx_state_e     state;
        logic [ZW-1:0] zrun;
        logic [AW-1:0] len;
        logic [AW-1:0] cnt;
        logic [15:0]   crc;
        logic          irq;
        logic          ok;
        logic [AW-1:0] plen;
    } rx_regs_t;

    localparam rx_regs_t RX_RESET = '{state: RX_HUNT, zrun: '0, len: '0, cnt: '0,
                                      crc: '0, irq: 1'b0, ok: 1'b0, plen: '0};

    rx_regs_t    q, d;
    logic [15:0] crc_next;

    always_comb begin
        d        = q;
        d.irq    = 1'b0;
        crc_next = crc16_step(q.crc, in_data);
        unique case (q.state)
            RX_HUNT: begin
                if (in_valid) begin
                    if ((in_data == DELIM) && (q.zrun == Z_FULL)) begin
                        d.state = RX_LENGTH;
                        d.zrun  = '0;
                    end else if (in_data == LEAD_BYTE) begin
                        if (q.zrun != Z_FULL) d.zrun = q.zrun + ZW'(1);
                    end else begin
                        d.zrun = '0;
                    end
                end
            end
            RX_LENGTH: begin
                if (in_valid) begin
                    if ((in_data < 8'd2) || (in_data > TOTAL_MAX)) begin
                        d.state = RX_HUNT;
                        d.zrun  = '0;
                    end else begin
                        d.state = RX_BODY;
                        d.len   = in_data[AW-1:0];
                        d.cnt   = '0;
                        d.crc   = '0;
                    end
                end
            end
            RX_BODY: begin
                if (in_valid) begin
                    if (q.cnt == q.len - AW'(1)) begin
                        // residue of payload plus appended check is zero on a match
                        d.state = RX_HUNT;
                        d.zrun  = '0;
                        d.irq   = 1'b1;
                        d.ok    = (crc_next == 16'h0000);
                        d.plen  = q.len - AW'(2);
                    end else begin
                        d.cnt = q.cnt + AW'(1);
                        d.crc = crc_next;
                    end
                end
            end
            default: d = RX_RESET;
        endcase
    end

    assign wr_en    = (q.state == RX_BODY) && in_valid;
    assign wr_addr  = q.cnt;
    assign wr_data  = in_data;
    assign done_irq = q.irq;
    assign crc_ok   = q.ok;
    assign pay_len  = q.plen;

    always_ff @(posedge clk) begin
        if (!rst_n) q <= RX_RESET;
        else        q <= d;
    end

endmodule

// File: rtl/phy_frame_engine.sv
module phy_frame_engine #(
    parameter int         PAYLOAD_MAX = 125,
    parameter int         LEAD_LEN    = 4,
    parameter int         LEAD_MATCH  = 2,
    parameter logic [7:0] DELIM       = 8'hA7,
    localparam int        AW          = $clog2(PAYLOAD_MAX + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          txb_we,
    input  logic [AW-1:0] txb_addr,
    input  logic [7:0]    txb_wdata,
    input  logic          tx_start,
    input  logic [AW-1:0] tx_len,
    output logic          txo_valid,
    output logic [7:0]    txo_data,
    input  logic          txo_ready,
    output logic          tx_irq,
    input  logic          rxi_valid,
    input  logic [7:0]    rxi_data,
    input  logic [AW-1:0] rxb_addr,
    output logic [7:0]    rxb_rdata,
    output logic          rx_irq,
    output logic          crc_valid,
    output logic [AW-1:0] rx_len
);
    logic [AW-1:0] tx_rd_addr;
    logic [7:0]    tx_rd_data;
    logic          rx_wr_en;
    logic [AW-1:0] rx_wr_addr;
    logic [7:0]    rx_wr_data;

    pf_byte_ram #(.AW(AW)) tx_buf_i (
        .clk   (clk),
        .we    (txb_we),
        .waddr (txb_addr),
        .wdata (txb_wdata),
        .raddr (tx_rd_addr),
        .rdata (tx_rd_data)
    );

    pf_tx_framer #(
        .PAYLOAD_MAX (PAYLOAD_MAX),
        .LEAD_LEN    (LEAD_LEN),
        .DELIM       (DELIM),
        .AW          (AW)
    ) tx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (tx_start),
        .len       (tx_len),
        .rd_addr   (tx_rd_addr),
        .rd_data   (tx_rd_data),
        .out_valid (txo_valid),
        .out_data  (txo_data),
        .out_ready (txo_ready),
        .done_irq  (tx_irq)
    );

    pf_rx_parser #(
        .PAYLOAD_MAX (PAYLOAD_MAX),
        .LEAD_MATCH  (LEAD_MATCH),
        .DELIM       (DELIM),
        .AW          (AW)
    ) rx_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (rxi_valid),
        .in_data  (rxi_data),
        .wr_en    (rx_wr_en),
        .wr_addr  (rx_wr_addr),
        .wr_data  (rx_wr_data),
        .done_irq (rx_irq),
        .crc_ok   (crc_valid),
        .pay_len  (rx_len)
    );

    pf_byte_ram #(.AW(AW)) rx_buf_i (
        .clk   (clk),
        .we    (rx_wr_en),
        .waddr (rx_wr_addr),
        .wdata (rx_wr_data),
        .raddr (rxb_addr),
        .rdata (rxb_rdata)
    );

endmodule

// File: rtl/phy_frame_engine_chk.sv
module phy_frame_engine_chk #(
    parameter int PAYLOAD_MAX = 125,
    parameter int AW          = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tx_start,
    input logic [AW-1:0] tx_len,
    input logic          txo_valid,
    input logic [7:0]    txo_data,
    input logic          txo_ready,
    input logic          tx_irq,
    input logic          rx_irq,
    input logic          crc_valid,
    input logic [AW-1:0] rx_len
);
    localparam logic [AW-1:0] MAX_LEN = AW'(PAYLOAD_MAX);

    p_frame_starts_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(txo_valid) |-> (txo_data == 8'h00));

    p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (txo_valid && !txo_ready) |=> (txo_valid && $stable(txo_data)));

    p_tx_irq_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |=> !tx_irq);

    p_tx_irq_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |-> !txo_valid);

    p_tx_end_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(txo_valid) |-> tx_irq);

    p_oversize_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!txo_valid && tx_start && (tx_len > MAX_LEN)) |=> !txo_valid);

    p_rx_len_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> (rx_len <= MAX_LEN));

    p_flags_move_with_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_irq |-> ($stable(crc_valid) && $stable(rx_len)));

    p_rx_irq_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |=> !rx_irq);

endmodule

bind phy_frame_engine phy_frame_engine_chk #(.PAYLOAD_MAX(PAYLOAD_MAX), .AW(AW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_start  (tx_start),
    .tx_len    (tx_len),
    .txo_valid (txo_valid),
    .txo_data  (txo_data),
    .txo_ready (txo_ready),
    .tx_irq    (tx_irq),
    .rx_irq    (rx_irq),
    .crc_valid (crc_valid),
    .rx_len    (rx_len)
);

// File: tb/phy_frame_engine_tb_top.sv
`timescale 1ns/1ps
module phy_frame_engine_tb_top;

    localparam int AW = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          txb_we = 1'b0;
    logic [AW-1:0] txb_addr = '0;
    logic [7:0]    txb_wdata = '0;
    logic          tx_start = 1'b0;
    logic [AW-1:0] tx_len = '0;
    logic          txo_valid;
    logic [7:0]    txo_data;
    logic          txo_ready = 1'b0;
    logic          tx_irq;
    logic          rxi_valid = 1'b0;
    logic [7:0]    rxi_data = '0;
    logic [AW-1:0] rxb_addr = '0;
    logic [7:0]    rxb_rdata;
    logic          rx_irq;
    logic          crc_valid;
    logic [AW-1:0] rx_len;

    always #2.5 clk = ~clk;

    phy_frame_engine dut_i (
        .clk(clk), .rst_n(rst_n),
        .txb_we(txb_we), .txb_addr(txb_addr), .txb_wdata(txb_wdata),
        .tx_start(tx_start), .tx_len(tx_len),
        .txo_valid(txo_valid), .txo_data(txo_data), .txo_ready(txo_ready),
        .tx_irq(tx_irq),
        .rxi_valid(rxi_valid), .rxi_data(rxi_data),
        .rxb_addr(rxb_addr), .rxb_rdata(rxb_rdata),
        .rx_irq(rx_irq), .crc_valid(crc_valid), .rx_len(rx_len)
    );

    int         checks = 0;
    int         fails  = 0;
    bit         finished = 1'b0;
    int         tx_irq_cnt = 0;
    int         rx_irq_cnt = 0;
    bit         rx_ok_seen = 1'b0;
    int         rx_len_seen = 0;
    bit         ready_rand = 1'b0;
    bit         stall_prev = 1'b0;
    logic [7:0] stall_data = '0;
    logic [7:0] tx_seen[$];
    logic [7:0] pay_q[$];
    logic [7:0] exp_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // Bit-serial reference: generator x^16+x^12+x^5+1, low bit first, seed zero.
    function automatic logic [15:0] ref_crc(input logic [7:0] bytes[$]);
        logic [15:0] c = 16'h0000;
        foreach (bytes[i]) begin
            for (int b = 0; b < 8; b++) begin
                logic fb;
                fb = bytes[i][b] ^ c[0];
                c  = c >> 1;
                if (fb) c = c ^ 16'h8408;
            end
        end
        return c;
    endfunction

    function automatic void build_frame(input bit corrupt);
        logic [15:0] c;
        c = ref_crc(pay_q);
        exp_q.delete();
        repeat (4) exp_q.push_back(8'h00);
        exp_q.push_back(8'hA7);
        exp_q.push_back(8'(pay_q.size() + 2));
        foreach (pay_q[i]) exp_q.push_back(pay_q[i]);
        exp_q.push_back(corrupt ? (c[7:0] ^ 8'h01) : c[7:0]);
        exp_q.push_back(c[15:8]);
    endfunction

    // Monitor: samples 1 ns after each falling edge.
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            if (stall_prev) begin
                chk(txo_valid && (txo_data == stall_data), "R4", "stalled byte held",
                    int'(txo_data), int'(stall_data));
            end
            stall_prev = txo_valid && !txo_ready;
            stall_data = txo_data;
            if (txo_valid && txo_ready) tx_seen.push_back(txo_data);
            if (tx_irq) tx_irq_cnt++;
            if (rx_irq) begin
                rx_irq_cnt++;
                rx_ok_seen  = crc_valid;
                rx_len_seen = int'(rx_len);
            end
        end
    end

    always @(negedge clk) begin
        txo_ready <= ready_rand ? ($urandom_range(3) != 0) : 1'b1;
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load_payload(input int n, input bit rnd);
        pay_q.delete();
        for (int i = 0; i < n; i++) pay_q.push_back(rnd ? 8'($urandom) : 8'(i * 7 + 3));
    endtask

    task automatic run_tx(input string req, input bit poke_busy);
        int base;
        int wait_n;
        @(negedge clk);
        foreach (pay_q[i]) begin
            txb_we = 1'b1; txb_addr = AW'(i); txb_wdata = pay_q[i];
            @(negedge clk);
        end
        txb_we = 1'b0;
        build_frame(1'b0);
        tx_seen.delete();
        base = tx_irq_cnt;
        tx_start = 1'b1; tx_len = AW'(pay_q.size());
        @(negedge clk);
        tx_start = 1'b0;
        if (poke_busy) begin
            cyc(6);
            tx_start = 1'b1; tx_len = AW'(3);
            @(negedge clk);
            tx_start = 1'b0;
        end
        wait_n = 0;
        while (tx_irq_cnt == base && wait_n < 3000) begin
            @(negedge clk); wait_n++;
        end
        cyc(12);
        chk(tx_irq_cnt == base + 1, req, "tx interrupt count", tx_irq_cnt - base, 1);
        chk(tx_seen.size() == exp_q.size(), req, "frame length", tx_seen.size(), exp_q.size());
        foreach (exp_q[i]) begin
            if (i < tx_seen.size())
                chk(tx_seen[i] == exp_q[i], req, $sformatf("frame byte %0d", i),
                    int'(tx_seen[i]), int'(exp_q[i]));
        end
        chk(!txo_valid, "R6", "idle after frame (no second launch)", int'(txo_valid), 0);
    endtask

    task automatic feed(input logic [7:0] bytes[$], input bit gaps);
        @(negedge clk);
        foreach (bytes[i]) begin
            if (gaps && $urandom_range(2) == 0) begin
                rxi_valid = 1'b0; rxi_data = 8'hFF;
                @(negedge clk);
            end
            rxi_valid = 1'b1; rxi_data = bytes[i];
            @(negedge clk);
        end
        rxi_valid = 1'b0; rxi_data = 8'h00;
        cyc(4);
    endtask

    task automatic run_rx(input string req, input bit corrupt, input bit gaps);
        int base;
        logic [7:0] s[$];
        build_frame(corrupt);
        s = exp_q;
        s.push_front(8'h55);
        base = rx_irq_cnt;
        feed(s, gaps);
        chk(rx_irq_cnt == base + 1, "R11", "rx interrupt count", rx_irq_cnt - base, 1);
        chk(rx_ok_seen == !corrupt, "R9", "check valid flag", int'(rx_ok_seen), int'(!corrupt));
        chk(rx_len_seen == pay_q.size(), "R8", "rx payload length", rx_len_seen, pay_q.size());
        for (int i = 0; i < pay_q.size() + 2; i++) begin
            rxb_addr = AW'(i);
            #1;
            chk(rxb_rdata == exp_q[i + 6], req, $sformatf("rx buffer %0d", i),
                int'(rxb_rdata), int'(exp_q[i + 6]));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog run did not complete actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] s[$];
        int base;
        bit prev_ok;
        int prev_len;
        void'($urandom(32'd20240611));
        cyc(4);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(!txo_valid, "R1", "txo_valid after reset", int'(txo_valid), 0);
        chk(!tx_irq,    "R1", "tx_irq after reset", int'(tx_irq), 0);
        chk(!rx_irq,    "R1", "rx_irq after reset", int'(rx_irq), 0);
        chk(!crc_valid, "R1", "crc_valid after reset", int'(crc_valid), 0);
        chk(rx_len == '0, "R1", "rx_len after reset", int'(rx_len), 0);

        // R3 known vector "123456789"
        pay_q.delete();
        for (int i = 0; i < 9; i++) pay_q.push_back(8'h31 + 8'(i));
        chk(ref_crc(pay_q) == 16'h2189, "R3", "reference vector", int'(ref_crc(pay_q)), 16'h2189);
        run_tx("R3", 1'b0);
        chk(tx_seen.size() == 17 && tx_seen[15] == 8'h89 && tx_seen[16] == 8'h21, "R3",
            "known check bytes", tx_seen.size() == 17 ? int'({tx_seen[16], tx_seen[15]}) : 0, 16'h2189);

        // R2 boundary lengths, then random with stalls (R4)
        load_payload(0, 1'b0);   run_tx("R2", 1'b0);
        load_payload(1, 1'b1);   run_tx("R2", 1'b0);
        load_payload(125, 1'b1); run_tx("R2", 1'b0);
        ready_rand = 1'b1;
        for (int k = 0; k < 5; k++) begin
            load_payload(int'($urandom_range(125)), 1'b1);
            run_tx("R2", 1'b0);
        end
        // R6 start while busy is ignored
        load_payload(20, 1'b1); run_tx("R6", 1'b1);
        ready_rand = 1'b0;

        // R6 oversize length ignored
        base = tx_irq_cnt;
        @(negedge clk);
        tx_start = 1'b1; tx_len = AW'(126);
        @(negedge clk);
        tx_start = 1'b0;
        cyc(30);
        chk(!txo_valid, "R6", "no frame for length 126", int'(txo_valid), 0);
        chk(tx_irq_cnt == base, "R6", "no irq for length 126", tx_irq_cnt - base, 0);

        // Receive: good, gapped (R12), corrupted, boundaries
        load_payload(10, 1'b1);  run_rx("R8", 1'b0, 1'b0);
        load_payload(40, 1'b1);  run_rx("R12", 1'b0, 1'b1);
        load_payload(17, 1'b1);  run_rx("R9", 1'b1, 1'b1);
        load_payload(0, 1'b0);   run_rx("R8", 1'b0, 1'b0);
        load_payload(125, 1'b1); run_rx("R8", 1'b0, 1'b1);
        for (int k = 0; k < 4; k++) begin
            load_payload(int'($urandom_range(125)), 1'b1);
            run_rx("R8", k[0], 1'b1);
        end

        // R7 a single zero before the delimiter is not enough
        base = rx_irq_cnt;
        s = '{8'h55, 8'h00, 8'hA7, 8'h05, 8'h11, 8'h22, 8'h33, 8'h44, 8'h66};
        feed(s, 1'b0);
        chk(rx_irq_cnt == base, "R7", "no frame after one zero", rx_irq_cnt - base, 0);

        // R10 illegal lengths dropped, flags unchanged, parser recovers
        prev_ok  = crc_valid;
        prev_len = int'(rx_len);
        base = rx_irq_cnt;
        s = '{8'h00, 8'h00, 8'hA7, 8'h80};
        feed(s, 1'b0);
        s = '{8'h00, 8'h00, 8'hA7, 8'h01};
        feed(s, 1'b0);
        chk(rx_irq_cnt == base, "R10", "no irq for bad length", rx_irq_cnt - base, 0);
        chk(crc_valid == prev_ok, "R10", "crc_valid unchanged", int'(crc_valid), int'(prev_ok));
        chk(int'(rx_len) == prev_len, "R10", "rx_len unchanged", int'(rx_len), prev_len);
        load_payload(6, 1'b1);
        run_rx("R10", 1'b0, 1'b0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule